// File: doc/BRIEF.md
# Three-Mode Interrupt Response Controller

This block is the interrupt and halt part of a processor's control logic. It holds the maskable-interrupt enable, a halt flag and a two-bit response mode. Small commands, decoded elsewhere, change these. When an interrupt request is accepted, the block runs one acknowledge cycle and captures the byte the interrupting device places on the data bus. What follows depends on the mode.

In mode 0 the captured byte is handed to the execution unit as the next instruction. In mode 1 the current program counter is pushed to the stack and execution restarts at a fixed address. In mode 2 the block also pushes the program counter. It then reads a 16-bit service address from a two-byte table entry and loads that address as the new program counter. The table entry's address is the I register value in the upper byte and the device byte in the lower byte.

Memory traffic uses a single request/acknowledge bus shared by the stack writes and the table reads. The new program counter and stack pointer appear on `pcOut`/`spOut` together with a one-cycle `pcLoad` strobe.

Top module: `intr_resp_ctl`

## Requirements
- R1: After reset the mode is 0, interrupts are disabled, `halted` is low and no strobe (`ackOut`, `insnValid`, `memReq`, `pcLoad`) is active.
- R2: `cmdOp` is taken when `cmdValid` is high, with 0 = disable, 1 = enable, 2 = halt, 3/4/5 = select mode 0/1/2, and 6–7 doing nothing. While interrupts are disabled, `irqReq` never raises `ackOut`.
- R3: In the idle state with interrupts enabled, `irqReq` is accepted at a clock edge. `ackOut` is then high for exactly the following cycle, and `devByte` and `iReg` are captured in that cycle.
- R4: Accepting an interrupt clears the interrupt enable. A further request is not acknowledged until an enable command is given.
- R5: A halt command raises `halted` from the next cycle. `halted` stays high until an interrupt is accepted, and it is low in the acknowledge cycle.
- R6: In mode 0, `insnValid` is high for the one cycle after the acknowledge cycle, with `insnOut` equal to the captured device byte. This happens with no memory access and no `pcLoad`.
- R7: In modes 1 and 2 the block writes the PC high byte to SP−1 and then the PC low byte to SP−2 (16-bit wraparound). Each write is held with a stable address and data until `memAck`.
- R8: In mode 1, `pcLoad` pulses for one cycle with `pcOut` = 0x0038 and `spOut` = SP−2.
- R9: In mode 2, after the pushes the block reads the low byte at {I, device byte} and then the high byte at that address +1 (16-bit wraparound). `pcLoad` then pulses with `pcOut` = {high, low} and `spOut` = SP−2.
- R10: Commands given while a response sequence is in progress are ignored. A command in the same idle cycle as an accepted request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| irqReq | input | 1 | Maskable interrupt request |
| devByte | input | 8 | Byte from the interrupting device, sampled in the acknowledge cycle |
| iReg | input | 8 | I register value |
| pcIn | input | 16 | Current program counter |
| spIn | input | 16 | Current stack pointer |
| ackOut | output | 1 | Interrupt acknowledge cycle |
| insnValid | output | 1 | Mode-0 instruction byte valid |
| insnOut | output | 8 | Instruction byte for the execution unit |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Access address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memAck |
| memAck | input | 1 | Access completes at this edge |
| pcLoad | output | 1 | New PC/SP valid |
| pcOut | output | 16 | New program counter |
| spOut | output | 16 | New stack pointer |
| halted | output | 1 | Halt flag |

## Verification
The hardest case to reach is a command that lands in the middle of a response sequence. It can only arrive while the block waits on memory, and its being dropped is visible only after the sequence ends. The bench pulses enable and halt commands during a mode-1 push. It then shows the effect at the ports: after `pcLoad`, `halted` is still low and a new request gets no acknowledge. The same-cycle clash of an enable command with an accepted request is checked in the same way. Mode-2 table addresses are chosen so the +1 step carries across the byte boundary, and the stack pointer is chosen so the push wraps below zero.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [2:0] {
    OP_DI   = 3'd0,
    OP_EI   = 3'd1,
    OP_HALT = 3'd2,
    OP_IM0  = 3'd3,
    OP_IM1  = 3'd4,
    OP_IM2  = 3'd5
  } cmdOp_e;

  typedef enum logic [1:0] {
    AS_PUSH_HI, AS_PUSH_LO, AS_TAB_LO, AS_TAB_HI
  } addrSel_e;

  typedef struct packed {
    logic     capture;
    logic     latchDev;
    logic     latchLo;
    logic     latchHi;
    logic     useTable;
    addrSel_e addrSel;
  } dpCtl_t;
endpackage

// File: rtl/intr_dp.sv
module intr_dp
  import intr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] RST_VEC = 'h0038
) (
  input  logic              clk,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] devByte,
  input  logic [DATA_W-1:0] iReg,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] insnOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut
);
  logic [ADDR_W-1:0] pcSave, spSave;
  logic [DATA_W-1:0] devSave, iSave, tabLo, tabHi;
  logic [ADDR_W-1:0] tabAddr;

  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      pcSave <= pcIn;
      spSave <= spIn;
    end
    if (ctl.latchDev) begin
      devSave <= devByte;
      iSave   <= iReg;
    end
    if (ctl.latchLo) tabLo <= memRdata;
    if (ctl.latchHi) tabHi <= memRdata;
  end

  assign tabAddr = {iSave, devSave};

  always_comb begin
    unique case (ctl.addrSel)
      AS_PUSH_HI: memAddr = spSave - ADDR_W'(1);
      AS_PUSH_LO: memAddr = spSave - ADDR_W'(2);
      AS_TAB_LO:  memAddr = tabAddr;
      default:    memAddr = tabAddr + ADDR_W'(1);
    endcase
  end

  assign memWdata = (ctl.addrSel == AS_PUSH_HI) ? pcSave[ADDR_W-1:DATA_W] : pcSave[DATA_W-1:0];
  assign insnOut  = devSave;
  assign pcOut    = ctl.useTable ? {tabHi, tabLo} : RST_VEC;
  assign spOut    = spSave - ADDR_W'(2);
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       irqReq,
  input  logic       memAck,
  output dpCtl_t     ctl,
  output logic       ackOut,
  output logic       insnValid,
  output logic       memReq,
  output logic       memWe,
  output logic       pcLoad,
  output logic       halted
);
  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_INSN, S_PUSH_HI, S_PUSH_LO, S_RD_LO, S_RD_HI, S_DONE
  } state_e;

  state_e     state, stateNx;
  logic       intEn;
  logic [1:0] mode;
  logic       accept;

  assign accept = (state == S_IDLE) && irqReq && intEn;

  always_comb begin
    stateNx = state;
    unique case (state)
      S_IDLE:    if (accept) stateNx = S_ACK;
      S_ACK:     stateNx = (mode == 2'd0) ? S_INSN : S_PUSH_HI;
      S_INSN:    stateNx = S_IDLE;
      S_PUSH_HI: if (memAck) stateNx = S_PUSH_LO;
      S_PUSH_LO: if (memAck) stateNx = (mode == 2'd2) ? S_RD_LO : S_DONE;
      S_RD_LO:   if (memAck) stateNx = S_RD_HI;
      S_RD_HI:   if (memAck) stateNx = S_DONE;
      default:   stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      intEn  <= 1'b0;
      mode   <= 2'd0;
      halted <= 1'b0;
    end else begin
      state <= stateNx;
      if (accept) begin
        intEn  <= 1'b0;
        halted <= 1'b0;
      end else if (state == S_IDLE && cmdValid) begin
        unique case (cmdOp)
          OP_DI:   intEn  <= 1'b0;
          OP_EI:   intEn  <= 1'b1;
          OP_HALT: halted <= 1'b1;
          OP_IM0:  mode   <= 2'd0;
          OP_IM1:  mode   <= 2'd1;
          OP_IM2:  mode   <= 2'd2;
          default: ;
        endcase
      end
    end
  end

  assign ackOut    = (state == S_ACK);
  assign insnValid = (state == S_INSN);
  assign memWe     = (state == S_PUSH_HI) || (state == S_PUSH_LO);
  assign memReq    = memWe || (state == S_RD_LO) || (state == S_RD_HI);
  assign pcLoad    = (state == S_DONE);

  always_comb begin
    ctl          = '0;
    ctl.capture  = accept;
    ctl.latchDev = (state == S_ACK);
    ctl.latchLo  = (state == S_RD_LO) && memAck;
    ctl.latchHi  = (state == S_RD_HI) && memAck;
    ctl.useTable = (mode == 2'd2);
    unique case (state)
      S_PUSH_LO: ctl.addrSel = AS_PUSH_LO;
      S_RD_LO:   ctl.addrSel = AS_TAB_LO;
      S_RD_HI:   ctl.addrSel = AS_TAB_HI;
      default:   ctl.addrSel = AS_PUSH_HI;
    endcase
  end

  // R2/R3: an acknowledge follows only a request seen in the previous cycle
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(irqReq));
  a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);
  a_r4_ie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> !intEn);
  a_r5_halt_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> ackOut);
  a_r6_mode0_quiet: assert property (@(posedge clk) disable iff (!rstN)
    insnValid |-> (!memReq && !pcLoad));
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(mode));
endmodule

// File: rtl/intr_resp_ctl.sv
module intr_resp_ctl
  import intr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] RST_VEC = 'h0038
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic                irqReq,
  input  logic [DATA_W-1:0]   devByte,
  input  logic [DATA_W-1:0]   iReg,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [2*DATA_W-1:0] spIn,
  output logic                ackOut,
  output logic                insnValid,
  output logic [DATA_W-1:0]   insnOut,
  output logic                memReq,
  output logic                memWe,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memAck,
  output logic                pcLoad,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [2*DATA_W-1:0] spOut,
  output logic                halted
);
  localparam int ADDR_W = 2 * DATA_W;
  dpCtl_t ctl;

  intr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .irqReq(irqReq), .memAck(memAck), .ctl(ctl), .ackOut(ackOut),
    .insnValid(insnValid), .memReq(memReq), .memWe(memWe),
    .pcLoad(pcLoad), .halted(halted)
  );

  intr_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)) u_dp (
    .clk(clk), .ctl(ctl), .devByte(devByte), .iReg(iReg), .pcIn(pcIn),
    .spIn(spIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .insnOut(insnOut), .pcOut(pcOut), .spOut(spOut)
  );

  // R7: a pending access holds its address and data until acknowledged
  a_r7_hold_access: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe)));
  a_r8_load_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);
endmodule

// File: tb/test_intr_resp_ctl.sv
module test_intr_resp_ctl;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  iv;
    logic [7:0]  dev;
    logic [15:0] pc;
    logic [15:0] sp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h12, 8'h40, 16'h1234, 16'hFFF0},
    '{2'd2, 8'h80, 8'h10, 16'hABCD, 16'h8000},
    '{2'd2, 8'h3C, 8'hFF, 16'h0102, 16'h4000},
    '{2'd1, 8'h00, 8'h00, 16'hFFFF, 16'h0001},
    '{2'd0, 8'h55, 8'hC9, 16'h2000, 16'h3000},
    '{2'd2, 8'hFF, 8'hFF, 16'h7E7E, 16'h0000}
  };

  logic clk = 0, rstN = 0, cmdValid = 0, irqReq = 0, memAck = 0;
  logic [2:0] cmdOp = 0;
  logic [7:0] devByte = 0, iReg = 0, memRdata, insnOut, memWdata;
  logic [15:0] pcIn = 0, spIn = 0, memAddr, pcOut, spOut;
  logic ackOut, insnValid, memReq, memWe, pcLoad, halted;
  int nTests = 0, nFail = 0, cyc = 0;
  int wN = 0, rN = 0;
  logic [15:0] wA [64];
  logic [7:0]  wD [64];
  logic [15:0] rA [64];

  always #(CLK_P/2) clk = ~clk;

  intr_resp_ctl i_intr_resp_ctl (.*);

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h31;
  endfunction
  assign memRdata = memFn(memAddr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memAck <= rstN && memReq && !memAck;
    if (memReq && memAck) begin
      if (memWe) begin wA[wN % 64] <= memAddr; wD[wN % 64] <= memWdata; wN <= wN + 1; end
      else begin rA[rN % 64] <= memAddr; rN <= rN + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin nFail++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic cmd(input logic [2:0] op);
    @(negedge clk); cmdValid = 1; cmdOp = op;
    @(negedge clk); cmdValid = 0;
  endtask

  // raise a request; returns whether ackOut appeared in the following cycle
  task automatic raise(input logic [7:0] iv, dv, input logic [15:0] pc, sp, output bit acked);
    @(negedge clk); irqReq = 1; iReg = iv; devByte = dv; pcIn = pc; spIn = sp;
    @(negedge clk); acked = ackOut; irqReq = 0;
  endtask

  task automatic waitLoad(output bit seen);
    seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (pcLoad) seen = 1;
    end
  endtask

  bit ok1, seen;
  int w0, r0;
  logic [15:0] ta, expPc;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!halted && !ackOut && !insnValid && !memReq && !pcLoad, "R1 reset outputs", {halted, ackOut, insnValid, memReq, pcLoad}, 0);
    rstN = 1;
    // R1/R2: interrupts disabled after reset, no acknowledge
    raise(8'h00, 8'h00, 16'h0, 16'h0, ok1);
    chk(!ok1, "R2 disabled after reset ignores request", ok1, 0);
    // R1: default mode 0 -> instruction byte
    cmd(3'd1);
    raise(8'h00, 8'hE7, 16'h0, 16'h0, ok1);
    chk(ok1, "R3 acknowledge after enable", ok1, 1);
    @(negedge clk);
    chk(insnValid && insnOut == 8'hE7, "R1 default mode 0 instruction", {insnValid, insnOut}, {1'b1, 8'hE7});

    // vector table walk
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      cmd(3'd3 + 3'(v.mode));
      cmd(3'd1);
      w0 = wN; r0 = rN;
      raise(v.iv, v.dev, v.pc, v.sp, ok1);
      chk(ok1 && !halted, "R3 acknowledge cycle", ok1, 1);
      @(negedge clk);
      chk(!ackOut, "R3 acknowledge lasts one cycle", ackOut, 0);
      if (v.mode == 2'd0) begin
        chk(insnValid && insnOut == v.dev && !memReq && !pcLoad, "R6 mode 0 instruction", {insnValid, insnOut}, {1'b1, v.dev});
        @(negedge clk);
        chk(!insnValid && wN == w0, "R6 single strobe no memory", {insnValid, 8'(wN - w0)}, 0);
      end else begin
        waitLoad(seen);
        chk(seen, "R8 pcLoad seen", seen, 1);
        chk(wN - w0 == 2 && wA[w0 % 64] == v.sp - 16'd1 && wD[w0 % 64] == v.pc[15:8], "R7 push high byte",
            {wA[w0 % 64], wD[w0 % 64]}, {v.sp - 16'd1, v.pc[15:8]});
        chk(wA[(w0 + 1) % 64] == v.sp - 16'd2 && wD[(w0 + 1) % 64] == v.pc[7:0], "R7 push low byte",
            {wA[(w0 + 1) % 64], wD[(w0 + 1) % 64]}, {v.sp - 16'd2, v.pc[7:0]});
        chk(spOut == v.sp - 16'd2, "R8 stack pointer", spOut, v.sp - 16'd2);
        if (v.mode == 2'd1) begin
          chk(pcOut == 16'h0038 && rN == r0, "R8 restart address", pcOut, 16'h0038);
        end else begin
          ta = {v.iv, v.dev};
          expPc = {memFn(ta + 16'd1), memFn(ta)};
          chk(rN - r0 == 2 && rA[r0 % 64] == ta && rA[(r0 + 1) % 64] == ta + 16'd1, "R9 table read order",
              {rA[r0 % 64], rA[(r0 + 1) % 64]}, {ta, ta + 16'd1});
          chk(pcOut == expPc, "R9 vectored address", pcOut, expPc);
        end
        @(negedge clk);
        chk(!pcLoad, "R8 pcLoad one cycle", pcLoad, 0);
      end
      // R4: enable cleared by accept
      raise(v.iv, v.dev, v.pc, v.sp, ok1);
      chk(!ok1, "R4 no nested acknowledge", ok1, 0);
    end

    // R2: explicit disable blocks
    cmd(3'd1); cmd(3'd0);
    raise(8'h1, 8'h2, 16'h3, 16'h4, ok1);
    chk(!ok1, "R2 disable blocks request", ok1, 0);
    // R2: undefined code does nothing (enable stays off)
    cmd(3'd7);
    raise(8'h1, 8'h2, 16'h3, 16'h4, ok1);
    chk(!ok1, "R2 unused code no effect", ok1, 0);

    // R5: halt until interrupt
    cmd(3'd4); cmd(3'd1); cmd(3'd2);
    chk(halted, "R5 halted after command", halted, 1);
    repeat (5) @(negedge clk);
    chk(halted, "R5 halted held", halted, 1);
    raise(8'h0, 8'h0, 16'h4444, 16'h2000, ok1);
    chk(ok1 && !halted, "R5 released in acknowledge cycle", {ok1, halted}, 2'b10);
    waitLoad(seen);

    // R10: commands during sequence ignored
    cmd(3'd1);
    raise(8'h0, 8'h0, 16'h5555, 16'h2000, ok1);
    @(negedge clk); cmdValid = 1; cmdOp = 3'd1;
    @(negedge clk); cmdOp = 3'd2;
    @(negedge clk); cmdValid = 0;
    waitLoad(seen);
    chk(seen && !halted, "R10 halt ignored while busy", halted, 0);
    raise(8'h0, 8'h0, 16'h0, 16'h0, ok1);
    chk(!ok1, "R10 enable ignored while busy", ok1, 0);

    // R10: command in same cycle as accept dropped
    cmd(3'd3); cmd(3'd1);
    @(negedge clk); irqReq = 1; cmdValid = 1; cmdOp = 3'd1; devByte = 8'h00;
    @(negedge clk); irqReq = 0; cmdValid = 0;
    chk(ackOut, "R10 request wins", ackOut, 1);
    repeat (2) @(negedge clk);
    raise(8'h0, 8'h0, 16'h0, 16'h0, ok1);
    chk(!ok1, "R10 same-cycle enable dropped", ok1, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule